// File: doc/BRIEF.md
# Direct-Mapped Byte Cache with Burst Line Refill

This block sits between a processor port and a 32-bit main-memory port. It holds 32 lines of 8 bytes, 256 bytes of data in all. Each line has a tag and a valid bit. In write-back builds, each line also has a dirty bit. The processor issues one byte read or byte write at a time and holds the request until the block answers with a one-cycle ready pulse. An access that finds its line present completes in the cycle after it is accepted.

An access whose line is absent does not get its byte early. The block fetches the whole line from memory as a burst of two 4-byte words, writes it into the line, and then runs the lookup again, which now hits. The memory answers a burst with a long wait before the first word and a shorter wait before the second.

The parameter `WRITE_BACK` selects how writes are handled:
- In write-through builds, every write goes to both the line and memory.
- In write-back builds, a write changes only the line and marks it modified. A modified line is copied back to memory just before another block replaces it.

Top module: `dmc_cache`

## Requirements
- R1: A 16-bit byte address splits into a tag in bits 15:8, a line index in bits 7:3 and a byte offset in bits 2:0. An access hits only when the indexed line is valid and its stored tag equals the address tag. Two addresses with the same index but different tags therefore displace each other.
- R2: Reset marks every line invalid, so the first access to any line issues a memory read burst. While reset is held and in the first idle cycle after it, `cpu_ready` and `mem_req` are low.
- R3: A read hit returns the addressed byte on `cpu_rdata` with `cpu_ready` high in the cycle after the request is accepted, and it causes no memory transaction.
- R4: A miss issues one read burst at the line base address (bits 2:0 zero) and receives word 0 (bytes 0 to 3) and then word 1 (bytes 4 to 7). Byte k of a word sits in bits 8k+7:8k. No byte is returned before the whole line is stored. The lookup is then replayed as a hit, so a clean read miss completes 6 + first-word latency + next-word latency cycles after the request is driven.
- R5: In write-through mode a write updates the cached line, if present, and issues exactly one memory word write. That write carries the address aligned down to 4, the byte replicated in all four lanes and a one-hot byte enable selected by address bits 1:0. `cpu_ready` rises in the cycle the memory acknowledges. No line is ever written back on a miss.
- R6: In write-back mode a write hit updates only the cached line, completes one cycle after acceptance, causes no memory traffic, and leaves memory unchanged.
- R7: In write-back mode a miss on a valid modified line first writes the old line's two words to memory, word 0 and then word 1, at the old tag's address with all byte enables set, and only then starts the refill. A miss on a clean line writes nothing.
- R8: A write miss allocates the line: the line is refilled first and the byte is then merged into it. Later reads of that line hit, returning the written byte and memory data for the other bytes.
- R9: After one refill, all 8 bytes of the line hit without further memory traffic.
- R10: `cpu_ready` is a single-cycle pulse, and a new request is accepted only when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_ready` on reads |
| mem_req | output | 1 | Memory transaction in progress |
| mem_we | output | 1 | 1 = word write, 0 = line read burst |
| mem_addr | output | 16 | Word-aligned byte address (line base for bursts) |
| mem_wdata | output | 32 | Write word |
| mem_be | output | 4 | Byte enables for writes |
| mem_valid | input | 1 | Read beat valid, or write acknowledge |
| mem_rdata | input | 32 | Read beat data |

## Verification
Each kind of wrong internal state shows up at the ports within one access:
- A stale valid bit or a wrong stored tag turns a miss into a hit. The wrong byte then appears on `cpu_rdata` one cycle after acceptance, with no read burst on the memory port.
- A lost dirty bit shows up at the next conflicting miss. The two write-back words never appear, and memory keeps its old byte.
- A wrong beat order or word select corrupts the bytes of one half of the line. The first read of that half shows the error.

Latency is also compared cycle for cycle. An extra or missing state in the refill or write path moves `cpu_ready` by at least one cycle.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  parameter int ADDR_W     = 16;
  parameter int LINE_BYTES = 8;
  parameter int NUM_LINES  = 32;
  parameter int WORD_BYTES = 4;

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WORDS  = LINE_BYTES / WORD_BYTES;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int LANE_W = $clog2(WORD_BYTES);
  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int SLOTS  = NUM_LINES * WORDS;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMP,
    ST_WT,
    ST_EVICT,
    ST_FILL
  } dmc_state_e;

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [WSEL_W-1:0] f_wsel(input logic [ADDR_W-1:0] a);
    return a[LANE_W +: WSEL_W];
  endfunction

  function automatic logic [LANE_W-1:0] f_lane(input logic [ADDR_W-1:0] a);
    return a[LANE_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] f_word_addr(input logic [TAG_W-1:0] t,
                                                    input logic [IDX_W-1:0] i,
                                                    input logic [WSEL_W-1:0] w);
    return {t, i, w, {LANE_W{1'b0}}};
  endfunction

  function automatic logic [WORD_BYTES-1:0] f_lane_be(input logic [LANE_W-1:0] l);
    return WORD_BYTES'(1) << l;
  endfunction
endpackage

// File: rtl/dmc_tags.sv
module dmc_tags
  import dmc_pkg::*;
#(
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic             lk_dirty,
  output logic [TAG_W-1:0] lk_tag,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_en
);
  logic [NUM_LINES-1:0] valid_q;
  logic [NUM_LINES-1:0] dirty_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (fill_en) valid_q[lk_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[lk_idx] <= fill_tag;
  end

  generate
    if (WRITE_BACK) begin : g_dirty
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        dirty_q <= '0;
        else if (fill_en)  dirty_q[lk_idx] <= 1'b0;
        else if (dirty_en) dirty_q[lk_idx] <= 1'b1;
      end
    end else begin : g_clean
      assign dirty_q = '0;
    end
  endgenerate

  assign lk_valid = valid_q[lk_idx];
  assign lk_dirty = dirty_q[lk_idx];
  assign lk_tag   = tag_q[lk_idx];

  // R2 / R4: a completed refill leaves the line valid, clean and tagged
  a_r4_fill_sets_line: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> lk_valid && !lk_dirty && (lk_tag == $past(fill_tag)));

  // R5: write-through lines are never marked modified
  a_r5_wt_never_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    !WRITE_BACK |-> !lk_dirty);
endmodule

// File: rtl/dmc_data.sv
module dmc_data
  import dmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [7:0]        rd_byte,
  input  logic [WSEL_W-1:0] ev_wsel,
  output logic [WORD_W-1:0] ev_word,
  input  logic              fill_en,
  input  logic [WSEL_W-1:0] fill_wsel,
  input  logic [WORD_W-1:0] fill_word,
  input  logic              byte_en,
  input  logic [OFF_W-1:0]  byte_off,
  input  logic [7:0]        byte_val
);
  logic [WORD_W-1:0] slot_q [SLOTS];
  logic [WORD_W-1:0] rd_word;
  logic [LANE_W-1:0] rd_lane;
  logic [LANE_W-1:0] wr_lane;

  assign rd_lane = rd_off[LANE_W-1:0];
  assign wr_lane = byte_off[LANE_W-1:0];

  always_ff @(posedge clk) begin
    if (fill_en) slot_q[{idx, fill_wsel}] <= fill_word;
    if (byte_en) slot_q[{idx, byte_off[OFF_W-1:LANE_W]}][{wr_lane, 3'b000} +: 8] <= byte_val;
  end

  assign rd_word = slot_q[{idx, rd_off[OFF_W-1:LANE_W]}];
  assign rd_byte = rd_word[{rd_lane, 3'b000} +: 8];
  assign ev_word = slot_q[{idx, ev_wsel}];

  // R8: refill and byte merge never target the array in the same cycle
  a_r8_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && byte_en));
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic              cpu_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_wdata,
  input  logic              lk_valid,
  input  logic              lk_dirty,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              tag_fill,
  output logic              dirty_set,
  output logic              data_fill,
  output logic              byte_merge,
  output logic [WSEL_W-1:0] beat_sel,
  input  logic [WORD_W-1:0] ev_word,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [WORD_BYTES-1:0] mem_be,
  input  logic              mem_valid
);
  dmc_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [7:0]        wd_q;
  logic [WSEL_W-1:0] cnt_q;

  logic cmp_w, hit_w, evict_need_w, last_beat_w, fill_beat_w, evict_beat_w;

  assign cmp_w        = (st_q == ST_CMP);
  assign hit_w        = lk_valid && (lk_tag == f_tag(addr_q));
  assign evict_need_w = WRITE_BACK && lk_valid && lk_dirty;
  assign last_beat_w  = (cnt_q == WSEL_W'(WORDS - 1));
  assign fill_beat_w  = (st_q == ST_FILL) && mem_valid;
  assign evict_beat_w = (st_q == ST_EVICT) && mem_valid;

  assign req_addr   = addr_q;
  assign req_wdata  = wd_q;
  assign beat_sel   = cnt_q;
  assign data_fill  = fill_beat_w;
  assign tag_fill   = fill_beat_w && last_beat_w;
  assign byte_merge = cmp_w && hit_w && we_q;
  assign dirty_set  = byte_merge && WRITE_BACK;

  assign cpu_ready = (cmp_w && hit_w && !(we_q && !WRITE_BACK)) ||
                     ((st_q == ST_WT) && mem_valid);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = '0;
    case (st_q)
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = f_word_addr(f_tag(addr_q), f_idx(addr_q), '0);
      end
      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = f_word_addr(lk_tag, f_idx(addr_q), cnt_q);
        mem_wdata = ev_word;
        mem_be    = '1;
      end
      ST_WT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = f_word_addr(f_tag(addr_q), f_idx(addr_q), f_wsel(addr_q));
        mem_wdata = {WORD_BYTES{wd_q}};
        mem_be    = f_lane_be(f_lane(addr_q));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (cpu_req) begin
          addr_q <= cpu_addr;
          we_q   <= cpu_we;
          wd_q   <= cpu_wdata;
          cnt_q  <= '0;
          st_q   <= ST_CMP;
        end
        ST_CMP: begin
          cnt_q <= '0;
          if (hit_w)             st_q <= (we_q && !WRITE_BACK) ? ST_WT : ST_IDLE;
          else if (evict_need_w) st_q <= ST_EVICT;
          else                   st_q <= ST_FILL;
        end
        ST_WT: if (mem_valid) st_q <= ST_IDLE;
        ST_EVICT: if (evict_beat_w) begin
          cnt_q <= last_beat_w ? '0 : cnt_q + WSEL_W'(1);
          if (last_beat_w) st_q <= ST_FILL;
        end
        ST_FILL: if (fill_beat_w) begin
          cnt_q <= last_beat_w ? '0 : cnt_q + WSEL_W'(1);
          if (last_beat_w) st_q <= ST_CMP;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3: a read is only answered from a matching valid line
  a_r3_read_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !we_q) |-> (cmp_w && hit_w));

  // R4: once the last beat is stored, the replayed lookup hits
  a_r4_replay_hits: assert property (@(posedge clk) disable iff (!rst_n)
    tag_fill |=> (cmp_w && hit_w));

  // R7: write-back traffic only for a valid modified victim
  a_r7_evict_dirty_only: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EVICT) |-> (lk_valid && lk_dirty));

  // R10: completion is a single-cycle pulse
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  // R4 / R5: address held while a transfer waits for memory
  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (!mem_req || $stable(mem_addr)));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
  import dmc_pkg::*;
#(
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic        cpu_ready,
  output logic [7:0]  cpu_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_valid,
  input  logic [31:0] mem_rdata
);
  logic [ADDR_W-1:0] req_addr;
  logic [7:0]        req_wdata;
  logic              lk_valid, lk_dirty;
  logic [TAG_W-1:0]  lk_tag;
  logic              tag_fill, dirty_set, data_fill, byte_merge;
  logic [WSEL_W-1:0] beat_sel;
  logic [WORD_W-1:0] ev_word;

  dmc_ctrl #(.WRITE_BACK(WRITE_BACK)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_ready (cpu_ready),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .lk_valid  (lk_valid),
    .lk_dirty  (lk_dirty),
    .lk_tag    (lk_tag),
    .tag_fill  (tag_fill),
    .dirty_set (dirty_set),
    .data_fill (data_fill),
    .byte_merge(byte_merge),
    .beat_sel  (beat_sel),
    .ev_word   (ev_word),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be),
    .mem_valid (mem_valid)
  );

  dmc_tags #(.WRITE_BACK(WRITE_BACK)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (f_idx(req_addr)),
    .lk_valid (lk_valid),
    .lk_dirty (lk_dirty),
    .lk_tag   (lk_tag),
    .fill_en  (tag_fill),
    .fill_tag (f_tag(req_addr)),
    .dirty_en (dirty_set)
  );

  dmc_data u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (f_idx(req_addr)),
    .rd_off    (req_addr[OFF_W-1:0]),
    .rd_byte   (cpu_rdata),
    .ev_wsel   (beat_sel),
    .ev_word   (ev_word),
    .fill_en   (data_fill),
    .fill_wsel (beat_sel),
    .fill_word (mem_rdata),
    .byte_en   (byte_merge),
    .byte_off  (req_addr[OFF_W-1:0]),
    .byte_val  (req_wdata)
  );
endmodule

// File: tb/dmc_mem_model.sv
module dmc_mem_model #(
  parameter int FLAT = 6,
  parameter int NLAT = 2,
  parameter int WLAT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [15:0] addr,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  output logic        valid,
  output logic [31:0] rdata,
  output int          rd_bursts,
  output int          wr_words,
  output logic [15:0] last_rd_addr,
  output logic [15:0] last_wr_addr,
  output logic [15:0] prev_wr_addr,
  output logic [3:0]  last_be
);
  logic [31:0] words [2048];
  logic        busy, hold;
  int          cnt;
  logic        beat;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] + 8'(a[15:8] * 8'd37);
  endfunction

  initial begin
    for (int w = 0; w < 2048; w++)
      for (int b = 0; b < 4; b++)
        words[w][8*b +: 8] = pat(16'(w * 4 + b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0; busy <= 1'b0; hold <= 1'b0; cnt <= 0; beat <= 1'b0;
      rdata <= '0; rd_bursts <= 0; wr_words <= 0;
      last_rd_addr <= '0; last_wr_addr <= '0; prev_wr_addr <= '0; last_be <= '0;
    end else begin
      valid <= 1'b0;
      if (hold) hold <= 1'b0;
      else if (!busy) begin
        if (req) begin
          busy <= 1'b1; beat <= 1'b0;
          cnt  <= we ? WLAT : FLAT;
        end
      end else if (cnt != 0) cnt <= cnt - 1;
      else begin
        valid <= 1'b1;
        if (we) begin
          for (int b = 0; b < 4; b++)
            if (be[b]) words[addr[12:2]][8*b +: 8] <= wdata[8*b +: 8];
          wr_words <= wr_words + 1;
          prev_wr_addr <= last_wr_addr;
          last_wr_addr <= addr;
          last_be <= be;
          busy <= 1'b0; hold <= 1'b1;
        end else begin
          rdata <= words[addr[12:2] + 11'(beat)];
          if (beat) begin
            busy <= 1'b0; hold <= 1'b1;
            rd_bursts <= rd_bursts + 1;
            last_rd_addr <= addr;
          end else begin
            beat <= 1'b1; cnt <= NLAT;
          end
        end
      end
    end
  end
endmodule

// File: tb/dmc_cache_tb.sv
`timescale 1ns/1ps
module dmc_cache_tb;
  localparam int FLAT = 6;
  localparam int NLAT = 2;
  localparam int WLAT = 3;
  localparam int MISS_LAT = 6 + FLAT + NLAT;
  localparam int WT_LAT = 4 + WLAT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // index 0: write-back build, index 1: write-through build
  logic        c_req [2];
  logic        c_we [2];
  logic [15:0] c_addr [2];
  logic [7:0]  c_wd [2];
  logic        c_rdy [2];
  logic [7:0]  c_rd [2];
  logic        m_req [2];
  logic        m_we [2];
  logic [15:0] m_addr [2];
  logic [31:0] m_wd [2];
  logic [3:0]  m_be [2];
  logic        m_valid [2];
  logic [31:0] m_rd [2];
  int          n_burst [2];
  int          n_wr [2];
  logic [15:0] l_rd [2];
  logic [15:0] l_wr [2];
  logic [15:0] p_wr [2];
  logic [3:0]  l_be [2];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] log_a [64];
  logic [7:0]  log_d [64];
  int          log_m [64];
  int          log_n = 0;

  dmc_cache #(.WRITE_BACK(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(c_req[0]), .cpu_we(c_we[0]), .cpu_addr(c_addr[0]),
    .cpu_wdata(c_wd[0]), .cpu_ready(c_rdy[0]), .cpu_rdata(c_rd[0]), .mem_req(m_req[0]),
    .mem_we(m_we[0]), .mem_addr(m_addr[0]), .mem_wdata(m_wd[0]), .mem_be(m_be[0]),
    .mem_valid(m_valid[0]), .mem_rdata(m_rd[0]));

  dmc_cache #(.WRITE_BACK(1'b0)) u_dut_wt (
    .clk(clk), .rst_n(rst_n), .cpu_req(c_req[1]), .cpu_we(c_we[1]), .cpu_addr(c_addr[1]),
    .cpu_wdata(c_wd[1]), .cpu_ready(c_rdy[1]), .cpu_rdata(c_rd[1]), .mem_req(m_req[1]),
    .mem_we(m_we[1]), .mem_addr(m_addr[1]), .mem_wdata(m_wd[1]), .mem_be(m_be[1]),
    .mem_valid(m_valid[1]), .mem_rdata(m_rd[1]));

  dmc_mem_model #(.FLAT(FLAT), .NLAT(NLAT), .WLAT(WLAT)) u_mem_wb (
    .clk(clk), .rst_n(rst_n), .req(m_req[0]), .we(m_we[0]), .addr(m_addr[0]),
    .wdata(m_wd[0]), .be(m_be[0]), .valid(m_valid[0]), .rdata(m_rd[0]),
    .rd_bursts(n_burst[0]), .wr_words(n_wr[0]), .last_rd_addr(l_rd[0]),
    .last_wr_addr(l_wr[0]), .prev_wr_addr(p_wr[0]), .last_be(l_be[0]));

  dmc_mem_model #(.FLAT(FLAT), .NLAT(NLAT), .WLAT(WLAT)) u_mem_wt (
    .clk(clk), .rst_n(rst_n), .req(m_req[1]), .we(m_we[1]), .addr(m_addr[1]),
    .wdata(m_wd[1]), .be(m_be[1]), .valid(m_valid[1]), .rdata(m_rd[1]),
    .rd_bursts(n_burst[1]), .wr_words(n_wr[1]), .last_rd_addr(l_rd[1]),
    .last_wr_addr(l_wr[1]), .prev_wr_addr(p_wr[1]), .last_be(l_be[1]));

  function automatic logic [7:0] initial_byte(input logic [15:0] a);
    logic [7:0] hi_mix;
    hi_mix = 8'(a[15:8] * 8'd37);
    return hi_mix + a[7:0];
  endfunction

  function automatic logic [7:0] expect_byte(input int m, input logic [15:0] a);
    logic [7:0] v;
    v = initial_byte(a);
    for (int k = 0; k < log_n; k++)
      if (log_m[k] == m && log_a[k] == a) v = log_d[k];
    return v;
  endfunction

  function automatic logic [7:0] mem_byte(input int m, input logic [15:0] a);
    if (m == 0) return u_mem_wb.words[a[12:2]][8*a[1:0] +: 8];
    return u_mem_wt.words[a[12:2]][8*a[1:0] +: 8];
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic access(input int m, input bit we, input logic [15:0] a,
                        input logic [7:0] d, output logic [7:0] rd, output int lat);
    c_req[m] = 1'b1; c_we[m] = we; c_addr[m] = a; c_wd[m] = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!c_rdy[m] && lat < 2000);
    rd = c_rd[m];
    c_req[m] = 1'b0; c_we[m] = 1'b0;
    @(negedge clk);
    chk("R10 ready drops after one cycle", int'(c_rdy[m]), 0);
    if (we && log_n < 64) begin
      log_a[log_n] = a; log_d[log_n] = d; log_m[log_n] = m; log_n++;
    end
  endtask

  task automatic read_expect(input int m, input logic [15:0] a, input string tag,
                             input int exp_lat, input int exp_bursts);
    logic [7:0] rd;
    int lat;
    int b0;
    b0 = n_burst[m];
    access(m, 1'b0, a, 8'h00, rd, lat);
    chk({tag, " data"}, int'(rd), int'(expect_byte(m, a)));
    if (exp_lat >= 0) chk({tag, " latency"}, lat, exp_lat);
    chk({tag, " burst count"}, n_burst[m] - b0, exp_bursts);
  endtask

  task automatic t_reset();
    chk("R2 wb ready low after reset", int'(c_rdy[0]), 0);
    chk("R2 wt ready low after reset", int'(c_rdy[1]), 0);
    chk("R2 wb mem_req low after reset", int'(m_req[0]), 0);
    chk("R2 wt mem_req low after reset", int'(m_req[1]), 0);
  endtask

  task automatic t_cold_miss();
    read_expect(0, 16'h0123, "R2 R4 cold read miss", MISS_LAT, 1);
    chk("R4 burst at line base", int'(l_rd[0]), 16'h0120);
  endtask

  task automatic t_line_hits();
    read_expect(0, 16'h0127, "R3 R9 hit upper word", 1, 0);
    read_expect(0, 16'h0120, "R9 hit lower word", 1, 0);
    read_expect(0, 16'h0124, "R9 hit word1 byte0", 1, 0);
  endtask

  task automatic t_index_conflict();
    read_expect(0, 16'h0923, "R1 same index new tag misses", MISS_LAT, 1);
    chk("R1 conflict burst base", int'(l_rd[0]), 16'h0920);
    read_expect(0, 16'h0123, "R1 displaced tag misses again", MISS_LAT, 1);
    read_expect(0, 16'h0128, "R1 next index misses", MISS_LAT, 1);
    chk("R1 next index burst base", int'(l_rd[0]), 16'h0128);
  endtask

  task automatic t_wb_write_hit();
    logic [7:0] rd;
    int lat;
    int w0;
    w0 = n_wr[0];
    access(0, 1'b1, 16'h0125, 8'hA5, rd, lat);
    chk("R6 write hit latency", lat, 1);
    chk("R6 no memory write", n_wr[0] - w0, 0);
    chk("R6 memory unchanged", int'(mem_byte(0, 16'h0125)), int'(initial_byte(16'h0125)));
    read_expect(0, 16'h0125, "R6 read back written byte", 1, 0);
  endtask

  task automatic t_wb_evict();
    int w0;
    w0 = n_wr[0];
    read_expect(0, 16'h0924, "R7 dirty victim miss", -1, 1);
    chk("R7 two words written back", n_wr[0] - w0, 2);
    chk("R7 word0 written first", int'(p_wr[0]), 16'h0120);
    chk("R7 word1 written second", int'(l_wr[0]), 16'h0124);
    chk("R7 full byte enables", int'(l_be[0]), 4'hF);
    chk("R7 memory holds modified byte", int'(mem_byte(0, 16'h0125)), 8'hA5);
    w0 = n_wr[0];
    read_expect(0, 16'h0125, "R7 clean victim refetch", MISS_LAT, 1);
    chk("R7 clean victim no write", n_wr[0] - w0, 0);
  endtask

  task automatic t_write_through();
    logic [7:0] rd;
    int lat;
    int w0;
    int b0;
    read_expect(1, 16'h0340, "R5 wt fill", MISS_LAT, 1);
    w0 = n_wr[1];
    b0 = n_burst[1];
    access(1, 1'b1, 16'h0342, 8'h3C, rd, lat);
    chk("R5 wt write latency", lat, WT_LAT);
    chk("R5 one word write", n_wr[1] - w0, 1);
    chk("R5 write address aligned", int'(l_wr[1]), 16'h0340);
    chk("R5 one-hot byte enable", int'(l_be[1]), 4'b0100);
    chk("R5 memory updated", int'(mem_byte(1, 16'h0342)), 8'h3C);
    chk("R5 write hit no burst", n_burst[1] - b0, 0);
    read_expect(1, 16'h0342, "R5 cache updated", 1, 0);
  endtask

  task automatic t_alloc();
    logic [7:0] rd;
    int lat;
    int b0;
    int w0;
    b0 = n_burst[0];
    access(0, 1'b1, 16'h0A66, 8'h77, rd, lat);
    chk("R8 wb write miss refills", n_burst[0] - b0, 1);
    read_expect(0, 16'h0A66, "R8 merged byte", 1, 0);
    read_expect(0, 16'h0A61, "R8 neighbour from memory", 1, 0);
    b0 = n_burst[1];
    w0 = n_wr[1];
    access(1, 1'b1, 16'h0B1E, 8'h99, rd, lat);
    chk("R8 wt write miss refills", n_burst[1] - b0, 1);
    chk("R8 wt write miss writes memory", n_wr[1] - w0, 1);
    chk("R8 wt memory byte", int'(mem_byte(1, 16'h0B1E)), 8'h99);
    read_expect(1, 16'h0B1E, "R8 wt merged byte", 1, 0);
    w0 = n_wr[1];
    read_expect(1, 16'h0318, "R5 wt conflict miss", MISS_LAT, 1);
    chk("R5 wt miss never writes back", n_wr[1] - w0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      c_req[i] = 1'b0; c_we[i] = 1'b0; c_addr[i] = '0; c_wd[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_miss();
    t_line_hits();
    t_index_conflict();
    t_wb_write_hit();
    t_wb_evict();
    t_write_through();
    t_alloc();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule